// File: doc/BRIEF.md
# Matrix Result Shift-Out Engine

This block returns the contents of a grid of accumulators to an external SPI host. It works after the multiply-accumulate core has finished. When the core reports that its results are final, the control sequence has entered its drain phase, and the host holds chip select low, the engine captures every accumulator into a private snapshot. It then shifts the snapshot out on MISO, one bit per host clock.

The SPI clock and chip select reach the block already synchronized into the system clock domain. The engine finds host clock edges by comparing the present sample with the previous one. It moves MISO on the launch edge, which by default is the falling edge, so the host can sample on the rising edge. The words go out back to back with no padding, so the default 4×4 grid of 10-bit words forms one 160-bit stream.

After the final bit, a one-cycle completion pulse is raised. Raising chip select part way through a stream abandons it. The next transfer starts again from the first word and takes a new snapshot.

Top module: `spi_result_serializer`

## Requirements
- R1: While `rst_n` is low, `miso` and `tx_done` are 0. After reset the engine is idle.
- R2: A transfer starts only at a clock edge where `calc_done` and `drain_en` are both 1 and `cs_n_s` is 0. In any other case the engine stays idle and `miso` stays 0.
- R3: `miso` is 0 whenever no transfer is active, including while idle and after completion.
- R4: Element [r][c] sits at `result_bus[(r*COLS+c)*DW +: DW]`. Elements go out in row-major order, [0][0] first and [ROWS-1][COLS-1] last. Each element goes out most significant bit first, with no gap between words. The first bit appears on `miso` in the cycle after the start edge.
- R5: `miso` moves to the next bit only when a launch edge is detected. A launch edge is a clock edge where `sclk_s` was 1 at the previous clock edge and is 0 now. Otherwise `miso` holds its value.
- R6: The whole result bus is captured at the start edge. Later changes on `result_bus` do not alter the stream in progress.
- R7: The launch edge that follows the last bit makes `tx_done` 1 for exactly one cycle, in the next cycle.
- R8: If `cs_n_s` is 1 during a transfer, the transfer is abandoned at that edge and `miso` returns to 0. The next transfer starts from the first bit with a new capture.
- R9: After completion, no new transfer starts until `drain_en` goes to 0 or `cs_n_s` goes to 1.
- R10: Once a transfer has started, dropping `calc_done` or `drain_en` does not stop it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| result_bus | input | ROWS*COLS*DW | Flattened accumulator grid, row-major, element 0 in the lowest bits |
| calc_done | input | 1 | Core reports its results are final |
| drain_en | input | 1 | Control sequence is in its drain phase |
| sclk_s | input | 1 | Synchronized SPI clock level |
| cs_n_s | input | 1 | Synchronized active-low chip select |
| miso | output | 1 | Serial data toward the host |
| tx_done | output | 1 | One-cycle pulse after the last bit |

## Verification
The embedded properties check several rules on every cycle. A transfer only begins when the start conditions held at the previous edge. MISO never moves without a launch edge. Chip select high always ends a transfer, the completion pulse is one cycle wide and follows an active transfer, and the bit counter stays in range. Bit order, the snapshot's immunity to later bus changes, the restart from the first bit after an abort, and the block on restarting after completion can only be shown by the bench. For these, the bench streams whole transfers against a queue-based model, with an uneven host clock, a bus that changes during the transfer, and enables that drop part way through.

// File: rtl/ser_pkg.sv
package ser_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_HOLD = 2'd2
   } ser_state_t;
endpackage : ser_pkg

// File: rtl/ser_edge_detect.sv
// Finds the launch edge of the synchronized host clock.
module ser_edge_detect #(
   parameter bit LAUNCH_ON_FALL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_lvl,
   output logic launch
);
   logic sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_lvl;
   end

   generate
      if (LAUNCH_ON_FALL) begin : g_fall
         assign launch = sclk_prev & ~sclk_lvl;
      end else begin : g_rise
         assign launch = ~sclk_prev & sclk_lvl;
      end
   endgenerate
endmodule : ser_edge_detect

// File: rtl/ser_shadow.sv
// Snapshot register that doubles as the output shifter, plus bit counter.
module ser_shadow #(
   parameter int TOTAL = 160
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TOTAL-1:0] load_vec,
   input  logic             advance,
   output logic             head_bit,
   output logic             at_last
);
   localparam int CW = (TOTAL > 1) ? $clog2(TOTAL) : 1;
   localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

   generate
      if (TOTAL < 2) begin : g_bad_total
         $error("ser_shadow: TOTAL must be at least 2");
      end
   endgenerate

   logic [TOTAL-1:0] shreg;
   logic [CW-1:0]    bit_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_cnt <= '0;
      end else if (load) begin
         shreg   <= load_vec;
         bit_cnt <= '0;
      end else if (advance) begin
         shreg   <= {shreg[TOTAL-2:0], 1'b0};
         bit_cnt <= bit_cnt + 1'b1;
      end
   end

   assign head_bit = shreg[TOTAL-1];
   assign at_last  = (bit_cnt == LAST);

   // R4: the position counter never runs past the final bit
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= LAST);
endmodule : ser_shadow

// File: rtl/ser_ctrl.sv
// Sequencer: idle -> send -> hold, with abort on chip select.
module ser_ctrl
   import ser_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic calc_done,
   input  logic drain_en,
   input  logic cs_n,
   input  logic launch,
   input  logic at_last,
   output logic load,
   output logic advance,
   output logic busy,
   output logic done
);
   ser_state_t state;
   logic       start_ok;

   assign start_ok = calc_done & drain_en & ~cs_n;
   assign load     = (state == ST_IDLE) & start_ok;
   assign advance  = (state == ST_SEND) & ~cs_n & launch & ~at_last;
   assign busy     = (state == ST_SEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: if (start_ok) state <= ST_SEND;
            ST_SEND: begin
               if (cs_n) begin
                  state <= ST_IDLE;
               end else if (launch && at_last) begin
                  state <= ST_HOLD;
                  done  <= 1'b1;
               end
            end
            ST_HOLD: if (cs_n || !drain_en) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2: a transfer begins only after all start conditions were present
   p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(calc_done && drain_en && !cs_n));

   // R8: chip select high always ends an active transfer
   p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cs_n) |=> !busy);

   // R7: completion pulse lasts one cycle
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: completion only ever follows an active transfer
   p_done_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));
endmodule : ser_ctrl

// File: rtl/spi_result_serializer.sv
module spi_result_serializer #(
   parameter int ROWS           = 4,
   parameter int COLS           = 4,
   parameter int DW             = 10,
   parameter bit LAUNCH_ON_FALL = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ROWS*COLS*DW-1:0]  result_bus,
   input  logic                     calc_done,
   input  logic                     drain_en,
   input  logic                     sclk_s,
   input  logic                     cs_n_s,
   output logic                     miso,
   output logic                     tx_done
);
   localparam int NWORDS = ROWS * COLS;
   localparam int TOTAL  = NWORDS * DW;

   generate
      if (ROWS < 1 || COLS < 1) begin : g_bad_grid
         $error("spi_result_serializer: grid dimensions must be positive");
      end
      if (DW < 1) begin : g_bad_width
         $error("spi_result_serializer: word width must be positive");
      end
   endgenerate

   // Reorder: element 0 lands in the top bits so it leaves first, MSB first.
   logic [TOTAL-1:0] snap_vec;
   generate
      for (genvar k = 0; k < NWORDS; k++) begin : g_pack
         assign snap_vec[TOTAL-1-k*DW -: DW] = result_bus[k*DW +: DW];
      end
   endgenerate

   logic launch, load, advance, busy, head_bit, at_last;

   ser_edge_detect #(.LAUNCH_ON_FALL(LAUNCH_ON_FALL)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_lvl (sclk_s),
      .launch   (launch)
   );

   ser_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .calc_done (calc_done),
      .drain_en  (drain_en),
      .cs_n      (cs_n_s),
      .launch    (launch),
      .at_last   (at_last),
      .load      (load),
      .advance   (advance),
      .busy      (busy),
      .done      (tx_done)
   );

   ser_shadow #(.TOTAL(TOTAL)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_vec (snap_vec),
      .advance  (advance),
      .head_bit (head_bit),
      .at_last  (at_last)
   );

   assign miso = busy & head_bit;

   // R5: without a launch edge inside a running transfer, the line holds
   p_miso_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(launch)) |-> $stable(miso));

   // R3: a completion pulse is never accompanied by data on the line
   p_quiet_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> !miso);
endmodule : spi_result_serializer

// File: tb/sim_spi_result_serializer.sv
`timescale 1ns/1ps
module sim_spi_result_serializer;
   localparam int ROWS = 4, COLS = 4, DW = 10;
   localparam int NW = ROWS * COLS, TOT = NW * DW;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic           rst_n = 1'b0;
   logic [TOT-1:0] result_bus = '0;
   logic           calc_done = 1'b0, drain_en = 1'b0, sclk_s = 1'b0, cs_n_s = 1'b1;
   logic           miso, tx_done;

   spi_result_serializer #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .result_bus(result_bus), .calc_done(calc_done),
      .drain_en(drain_en), .sclk_s(sclk_s), .cs_n_s(cs_n_s),
      .miso(miso), .tx_done(tx_done));

   // Behavioural reference: 0 idle, 1 sending, 2 finished
   int   m_st = 0;
   bit   m_prev = 0;
   bit   m_q[$];
   bit   m_done = 0;
   int   vecs = 0, errs = 0;
   bit   finished = 0;
   string cur_req = "R1";

   function automatic bit exp_miso();
      return (m_st == 1 && m_q.size() > 0) ? m_q[0] : 1'b0;
   endfunction

   task automatic model_step();
      bit fall;
      if (!rst_n) begin
         m_st = 0; m_prev = 0; m_done = 0; m_q.delete();
         return;
      end
      fall   = m_prev && !sclk_s;
      m_prev = sclk_s;
      m_done = 0;
      case (m_st)
         0: if (calc_done && drain_en && !cs_n_s) begin
               m_q.delete();
               for (int k = 0; k < NW; k++)
                  for (int b = DW - 1; b >= 0; b--)
                     m_q.push_back(result_bus[k*DW + b]);
               m_st = 1;
            end
         1: if (cs_n_s) m_st = 0;
            else if (fall) begin
               if (m_q.size() == 1) begin m_st = 2; m_done = 1; end
               else void'(m_q.pop_front());
            end
         default: if (cs_n_s || !drain_en) m_st = 0;
      endcase
   endtask

   task automatic tick();
      model_step();
      @(negedge clk);
      vecs++;
      if (miso !== exp_miso() || tx_done !== m_done) begin
         errs++;
         $display("FAIL %s t=%0t: miso=%b exp %b, tx_done=%b exp %b",
                  cur_req, $time, miso, exp_miso(), tx_done, m_done);
      end
   endtask

   task automatic sclk_run(int n, int hi, int lo);
      for (int i = 0; i < n; i++) begin
         sclk_s = 1'b1; repeat (hi) tick();
         sclk_s = 1'b0; repeat (lo) tick();
      end
   endtask

   task automatic fill(int seed);
      for (int k = 0; k < NW; k++)
         result_bus[k*DW +: DW] = DW'((k * seed + 3 * k * k + 5) % 1024);
      result_bus[0 +: DW]        = 10'h3FF;
      result_bus[(NW-1)*DW +: DW] = 10'h201;
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errs++;
         $display("FAIL watchdog: actual hung, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      repeat (4) tick();
      @(posedge clk); #1 rst_n = 1'b1;   // released away from edges
      @(negedge clk);
      fill(37);
      repeat (2) tick();

      // R2: gate partially open, host clocking: stays silent
      cur_req = "R2";
      cs_n_s = 1'b0; calc_done = 1'b1; drain_en = 1'b0;
      sclk_run(6, 1, 2);
      calc_done = 1'b0; drain_en = 1'b1;
      sclk_run(6, 2, 1);
      calc_done = 1'b1; cs_n_s = 1'b1;
      sclk_run(6, 1, 1);

      // R4 R5 R6 R10: full transfer with uneven clock and changing bus
      cur_req = "R4";
      cs_n_s = 1'b0;
      repeat (3) tick();
      cur_req = "R5";
      sclk_run(40, 1, 3);
      cur_req = "R6";
      fill(91);
      sclk_run(40, 2, 2);
      cur_req = "R10";
      calc_done = 1'b0; drain_en = 1'b0;
      sclk_run(40, 1, 1);
      cur_req = "R7";
      drain_en = 1'b1;
      sclk_run(40, 3, 2);
      repeat (3) tick();

      // R9 R3: finished, clock continues, no restart while gate held
      cur_req = "R9";
      calc_done = 1'b1;
      sclk_run(20, 1, 2);
      cur_req = "R3";
      drain_en = 1'b0;
      sclk_run(4, 1, 1);

      // R8: abort mid-stream, restart from first bit with fresh capture
      cur_req = "R8";
      fill(13);
      drain_en = 1'b1;
      repeat (2) tick();
      sclk_run(50, 1, 2);
      cs_n_s = 1'b1;
      sclk_run(3, 1, 1);
      fill(58);
      cs_n_s = 1'b0;
      repeat (2) tick();
      sclk_run(160, 1, 1);
      repeat (4) tick();

      // R2: after leaving hold by chip select, a fresh frame restarts
      cur_req = "R2";
      cs_n_s = 1'b1; repeat (2) tick();
      cs_n_s = 1'b0; repeat (2) tick();
      sclk_run(10, 2, 1);
      cs_n_s = 1'b1; repeat (3) tick();

      finished = 1;
      summary();
      $finish;
   end
endmodule : sim_spi_result_serializer